// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block gives the processors of a multi-core system 32 hardware lock words for guarding shared resources. A processor claims a lock by writing its nonzero 4-bit master ID into that lock's register. It then reads the register back. If the low nibble matches its own ID, it holds the lock. Writing a value whose low nibble is zero hands the lock back. A write that tries to claim a lock that is already held is dropped without any effect, so the read-back tells each contender whether it won.

Several bus ports share the bank. Each port has an address, a write strobe, write data and combinational read data. When writes from different ports reach the same register in one cycle, the lower-numbered port wins. The bank also holds a mode register with one protocol-select bit, and a per-lock event flag that is set on every release. Writing a fixed key to a clear register wipes all the event flags.

Top module: `hsem_bank`

## Requirements
- R1: After a synchronous active-low reset, every lock reads 0 (free), the mode register reads 0 and all event flags are 0.
- R2: Lock i is at byte offset 0x08 + 4*i for i in 0..31. Reading it returns the owner ID in bits [3:0], and bits [31:4] read 0. Every port reads the same state.
- R3: A write to a free lock takes bits [3:0] of the write data as the claim ID. A nonzero ID makes that ID the owner, and a read in the following cycle returns it. Bits [31:4] of the write data are ignored.
- R4: A write with a nonzero claim ID to a lock that is already held leaves the owner unchanged.
- R5: A write whose bits [3:0] are zero to a held lock frees it, and sets event flag bit i for lock i in the next cycle. The same write to a free lock changes nothing and sets no flag.
- R6: When several ports write the same lock in one cycle, only the write from the lowest-numbered port takes effect. This holds for both claims and releases.
- R7: The mode register is at offset 0x00. Bit 0 is read/write and resets to 0, and bits [31:1] read 0. Port priority is the same as in R6.
- R8: The clear register is at offset 0x90. A write whose bits [15:0] equal 0xFFFF clears all event flags, and any other value is ignored. A read of 0x90 returns the flags, with bit i for lock i. A release in the same cycle as a clear keeps its flag set.
- R9: Unmapped offsets read 0 and ignore writes. This includes 0x04, misaligned addresses and offsets from 0x88 to 0x8C.
- R10: A write to one lock never changes any other lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | NUM_PORTS x ADDR_W | Byte address per port |
| bus_we | input | NUM_PORTS | Write strobe per port |
| bus_wdata | input | NUM_PORTS x DATA_W | Write data per port |
| bus_rdata | output | NUM_PORTS x DATA_W | Combinational read data per port |
| proto_sel | output | 1 | Mode register bit 0 |
| irq_flags | output | NUM_SEM | Release event flags, bit i for lock i |

## Verification
Claims are tried with several IDs: on free locks, on held locks, and with junk in the upper data bits. These cases separate the free-vs-held decision from plain storage of the written value. Zero-nibble writes go to both held and free locks, which shows that release and its flag depend on the lock's state. Colliding writes from two ports (claim against claim, and release against claim) expose which port has priority. A release that lands in the same cycle as a flag clear shows whether the clear can swallow a new event. Writes to unmapped and neighbouring offsets, followed by read-backs of other locks, catch decode aliasing.

// File: rtl/hsem_pkg.sv
// hsem_pkg: constants shared by the semaphore bank.
// Assumes a byte-addressed register space with 32-bit aligned registers.
package hsem_pkg;
    localparam int unsigned ID_W     = 4;
    localparam int unsigned SEM_BASE = 8;        // first lock register offset
    localparam int unsigned CTRL_OFS = 0;        // mode register offset
    localparam int unsigned CLR_OFS  = 144;      // flag clear register offset (0x90)
    localparam logic [15:0] CLR_KEY  = 16'hFFFF; // value that triggers a clear
endpackage

// File: rtl/hsem_addr_dec.sv
// hsem_addr_dec: decodes one port's byte address into a one-hot lock
// select plus mode and clear register hits.
// Assumes SEM_BASE + 4*NUM_SEM stays below CLR_OFS and fits in ADDR_W.
module hsem_addr_dec
    import hsem_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_SEM = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SEM-1:0] sem_hit,
    output logic               ctrl_hit,
    output logic               clr_hit
);
    // One comparator per lock register; exact match implies alignment.
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
        assign sem_hit[i] = (addr == ADDR_W'(SEM_BASE + 4 * i));
    end

    // Single-register hits for mode and clear.
    assign ctrl_hit = (addr == ADDR_W'(CTRL_OFS));
    assign clr_hit  = (addr == ADDR_W'(CLR_OFS));
endmodule

// File: rtl/hsem_cell.sv
// hsem_cell: one lock word. Picks the lowest-numbered writing port, then
// applies claim-if-free or release-if-held. Emits a one-cycle release event.
// Assumes req is already qualified with write strobe and address match.
module hsem_cell
    import hsem_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             req,
    input  logic [NUM_PORTS-1:0][ID_W-1:0]   wid,
    output logic [ID_W-1:0]                  owner,
    output logic                             rel_set
);
    logic            win_vld;
    logic [ID_W-1:0] win_id;
    logic            held;

    assign held = (owner != '0);

    // Fixed priority: the first requesting port in index order wins.
    always_comb begin
        win_vld = 1'b0;
        win_id  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req[p] && !win_vld) begin
                win_vld = 1'b1;
                win_id  = wid[p];
            end
        end
    end

    // Owner register: claim only when free, release only when held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= '0;
        end else if (win_vld) begin
            if (!held && win_id != '0) begin
                owner <= win_id;
            end else if (held && win_id == '0) begin
                owner <= '0;
            end
        end
    end

    // Release event towards the flag register.
    assign rel_set = win_vld && held && (win_id == '0);

    a_r3_claim_free: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld && !held && win_id != '0) |=> (owner == $past(win_id)));

    a_r4_held_ignores_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !(req != '0 && wid[0] == '0 && req[0])
              && !(req[0] == 1'b0 && req != '0 && win_id == '0)) |=> $stable(owner));

    a_r5_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (req[0] && wid[0] == '0 && held) |=> (owner == '0));

    a_r6_port0_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req[0] && !held && wid[0] != '0) |=> (owner == $past(wid[0])));
endmodule

// File: rtl/hsem_ctrl.sv
// hsem_ctrl: mode register and release event flags with keyed clear.
// Assumes per-port strobes are already address-qualified.
module hsem_ctrl
    import hsem_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned NUM_SEM   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          ctrl_we,
    input  logic [NUM_PORTS-1:0]          ctrl_bit,
    input  logic [NUM_PORTS-1:0]          clr_we,
    input  logic [NUM_PORTS-1:0][15:0]    clr_val,
    input  logic [NUM_SEM-1:0]            rel_set,
    output logic                          proto_sel,
    output logic [NUM_SEM-1:0]            flags
);
    logic ctrl_vld;
    logic ctrl_nxt;
    logic clr_any;

    // Mode write priority: lowest-numbered port decides the bit.
    always_comb begin
        ctrl_vld = 1'b0;
        ctrl_nxt = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (ctrl_we[p] && !ctrl_vld) begin
                ctrl_vld = 1'b1;
                ctrl_nxt = ctrl_bit[p];
            end
        end
    end

    // Clear fires if any port writes the key.
    always_comb begin
        clr_any = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            clr_any = clr_any | (clr_we[p] && clr_val[p] == CLR_KEY);
        end
    end

    // Mode register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        proto_sel <= 1'b0;
        else if (ctrl_vld) proto_sel <= ctrl_nxt;
    end

    // Flag storage: clear first, then new events so none are lost.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr_any ? '0 : flags) | rel_set;
    end

    a_r7_port0_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we[0] |=> (proto_sel == $past(ctrl_bit[0])));

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we[0] && clr_val[0] == CLR_KEY && rel_set == '0) |=> (flags == '0));

    a_r8_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_set != '0) |=> ((flags & $past(rel_set)) == $past(rel_set)));

    a_r5_flags_only_from_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_set == '0 && clr_we == '0) |=> $stable(flags));
endmodule

// File: rtl/hsem_bank.sv
// hsem_bank: multi-port bank of lock words with mode and flag registers.
// Reads are combinational from registered state; writes land on the clock.
// Assumes NUM_SEM <= DATA_W and DATA_W >= 16.
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int unsigned NUM_SEM   = 32,
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     bus_addr,
    input  logic [NUM_PORTS-1:0]                 bus_we,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]     bus_wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]     bus_rdata,
    output logic                                 proto_sel,
    output logic [NUM_SEM-1:0]                   irq_flags
);
    logic [NUM_PORTS-1:0][NUM_SEM-1:0] sem_hit;
    logic [NUM_PORTS-1:0]              ctrl_hit;
    logic [NUM_PORTS-1:0]              clr_hit;
    logic [NUM_PORTS-1:0][ID_W-1:0]    wr_id;
    logic [NUM_PORTS-1:0]              ctrl_bit;
    logic [NUM_PORTS-1:0][15:0]        clr_val;
    logic [NUM_SEM-1:0][ID_W-1:0]      owner;
    logic [NUM_SEM-1:0]                rel_set;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [DATA_W-1:0] rd;
        logic              unused_wdata_hi;

        hsem_addr_dec #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM)) u_dec (
            .addr     (bus_addr[p]),
            .sem_hit  (sem_hit[p]),
            .ctrl_hit (ctrl_hit[p]),
            .clr_hit  (clr_hit[p])
        );

        assign wr_id[p]        = bus_wdata[p][ID_W-1:0];
        assign ctrl_bit[p]     = bus_wdata[p][0];
        assign clr_val[p]      = bus_wdata[p][15:0];
        assign unused_wdata_hi = ^bus_wdata[p][DATA_W-1:16];

        // Read mux: lock owner, mode bit, flags, or zero.
        always_comb begin
            rd = '0;
            for (int s = 0; s < NUM_SEM; s++) begin
                if (sem_hit[p][s]) rd[ID_W-1:0] = rd[ID_W-1:0] | owner[s];
            end
            if (ctrl_hit[p]) rd[0] = proto_sel;
            if (clr_hit[p])  rd    = DATA_W'(irq_flags);
        end

        assign bus_rdata[p] = rd;
    end

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
        logic [NUM_PORTS-1:0] req;

        // Per-lock request vector across ports.
        always_comb begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                req[p] = bus_we[p] & sem_hit[p][s];
            end
        end

        hsem_cell #(.NUM_PORTS(NUM_PORTS)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req),
            .wid     (wr_id),
            .owner   (owner[s]),
            .rel_set (rel_set[s])
        );
    end

    hsem_ctrl #(.NUM_PORTS(NUM_PORTS), .NUM_SEM(NUM_SEM)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (bus_we & ctrl_hit),
        .ctrl_bit  (ctrl_bit),
        .clr_we    (bus_we & clr_hit),
        .clr_val   (clr_val),
        .rel_set   (rel_set),
        .proto_sel (proto_sel),
        .flags     (irq_flags)
    );

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_hit[0] != '0) |-> (bus_rdata[0][DATA_W-1:ID_W] == '0));

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_hit[0] == '0 && !ctrl_hit[0] && !clr_hit[0]) |-> (bus_rdata[0] == '0));
endmodule

// File: tb/sim_hsem_bank.sv
`timescale 1ns/1ps
module sim_hsem_bank;
    localparam int NP = 2;
    localparam int NV = 11;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NP-1:0][7:0]    bus_addr = '0;
    logic [NP-1:0]         bus_we = '0;
    logic [NP-1:0][31:0]   bus_wdata = '0;
    logic [NP-1:0][31:0]   bus_rdata;
    logic                  proto_sel;
    logic [31:0]           irq_flags;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hsem_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .proto_sel(proto_sel), .irq_flags(irq_flags)
    );

    // Vector table, port 0: address, write data, expected read-back, requirement.
    localparam logic [7:0]  V_ADDR [NV] = '{8'h08, 8'h08, 8'h84, 8'h0C, 8'h08,
                                            8'h04, 8'h09, 8'h00, 8'h00, 8'h88, 8'h0C};
    localparam logic [31:0] V_DATA [NV] = '{32'h3, 32'h5, 32'hFFFF_FFF7, 32'h10, 32'h0,
                                            32'h9, 32'h9, 32'hFFFF_FFFF, 32'h0, 32'h2, 32'h0};
    localparam logic [31:0] V_EXP  [NV] = '{32'h3, 32'h3, 32'h7, 32'h0, 32'h0,
                                            32'h0, 32'h0, 32'h1, 32'h0, 32'h0, 32'h0};
    // R3, R4, R2, R5, R5, R9, R9, R7, R7, R9, R10
    localparam int          V_REQ  [NV] = '{3, 4, 2, 5, 5, 9, 9, 7, 7, 9, 10};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr[p] = a; bus_wdata[p] = d; bus_we[p] = 1'b1;
        @(negedge clk);
        bus_we[p] = 1'b0;
    endtask

    task automatic rd(input int p, input logic [7:0] a, output logic [31:0] d);
        bus_addr[p] = a;
        #1;
        d = bus_rdata[p];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1: reset state
        rd(0, 8'h08, v); check("R1 lock0", v, 32'h0);
        rd(0, 8'h84, v); check("R1 lock31", v, 32'h0);
        rd(0, 8'h00, v); check("R1 mode", v, 32'h0);
        rd(0, 8'h90, v); check("R1 flags", v, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tg;
            wr(0, V_ADDR[i], V_DATA[i]);
            rd(0, V_ADDR[i], v);
            tg = $sformatf("R%0d vec%0d", V_REQ[i], i);
            check(tg, v, V_EXP[i]);
        end

        // R5: only the lock0 release raised a flag; free-lock zero write did not
        check("R5 flag port", irq_flags, 32'h1);
        rd(1, 8'h90, v); check("R5 flag read port1", v, 32'h1);
        rd(1, 8'h84, v); check("R2 port1 sees lock31", v, 32'h7);

        // R8: wrong key ignored, right key clears
        wr(0, 8'h90, 32'h1234); rd(0, 8'h90, v); check("R8 wrong key", v, 32'h1);
        wr(0, 8'h90, 32'hFFFF); rd(0, 8'h90, v); check("R8 clear", v, 32'h0);

        // R8: release of lock31 in the same cycle as a clear keeps its flag
        @(negedge clk);
        bus_addr[0] = 8'h84; bus_wdata[0] = 32'h0;    bus_we[0] = 1'b1;
        bus_addr[1] = 8'h90; bus_wdata[1] = 32'hFFFF; bus_we[1] = 1'b1;
        @(negedge clk);
        bus_we = '0;
        check("R8 event survives clear", irq_flags, 32'h8000_0000);
        rd(0, 8'h84, v); check("R5 lock31 freed", v, 32'h0);

        // R6: colliding claims on lock2, port0 wins
        @(negedge clk);
        bus_addr[0] = 8'h10; bus_wdata[0] = 32'h4; bus_we[0] = 1'b1;
        bus_addr[1] = 8'h10; bus_wdata[1] = 32'h6; bus_we[1] = 1'b1;
        @(negedge clk);
        bus_we = '0;
        rd(0, 8'h10, v); check("R6 claim collision p0", v, 32'h4);
        rd(1, 8'h10, v); check("R6 claim collision p1 view", v, 32'h4);

        // R6: port0 release beats port1 claim on the same lock
        @(negedge clk);
        bus_addr[0] = 8'h10; bus_wdata[0] = 32'h0; bus_we[0] = 1'b1;
        bus_addr[1] = 8'h10; bus_wdata[1] = 32'h6; bus_we[1] = 1'b1;
        @(negedge clk);
        bus_we = '0;
        rd(0, 8'h10, v); check("R6 release beats claim", v, 32'h0);

        // R7: port0 beats port1 on the mode register
        @(negedge clk);
        bus_addr[0] = 8'h00; bus_wdata[0] = 32'h0; bus_we[0] = 1'b1;
        bus_addr[1] = 8'h00; bus_wdata[1] = 32'h1; bus_we[1] = 1'b1;
        @(negedge clk);
        bus_we = '0;
        check("R7 mode priority", {31'b0, proto_sel}, 32'h0);

        // R10: claim lock3 from port1, neighbours stay free
        wr(1, 8'h14, 32'hA);
        rd(1, 8'h14, v); check("R10 lock3 owned", v, 32'hA);
        rd(0, 8'h18, v); check("R10 lock4 untouched", v, 32'h0);
        rd(0, 8'h10, v); check("R10 lock2 untouched", v, 32'h0);

        // R1: reset mid-run frees locks and zeroes mode
        wr(0, 8'h00, 32'h1);
        do_reset();
        rd(0, 8'h14, v); check("R1 lock3 after reset", v, 32'h0);
        check("R1 mode after reset", {31'b0, proto_sel}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule